// File: doc/BRIEF.md
# Addressable-LED Frame Streamer with SPI Frame Fetch

This block moves one frame of color data from a host to a strand of single-wire addressable LEDs. It is the SPI master. The host sits on the other end as an SPI slave and supplies the bytes. A frame holds three color bytes for every pixel named on the pixel-count input. The block never stores a whole frame. It keeps one byte in a prefetch register and a second byte in the output shifter, and it fetches the next byte over SPI while the current byte is being encoded onto the LED line. The LED bit rate therefore sets the frame rate, and the SPI clock only has to stay well ahead of it.

The host paces frames with an active-low frame-sync level. When the block is idle it samples this level, and it starts a new frame only while the level is low. If the host holds frame-sync low, frames repeat back to back, separated only by the latch gap. If the host pulses frame-sync at a slower rate, SS falls one cycle after each pulse is seen. After the last bit cell of a frame the LED line stays low for a latch interval. Only after that interval does the block look at frame-sync again. An active-low reset abandons any frame at once.

Top module: `led_frame_streamer`

## Requirements
- R1: For a pixel count N greater than zero, a frame consists of 3·N bytes and exactly 24·N bit cells on the LED line.
- R2: SS falls only from idle, and only on a clock edge at which frameSyncN is sampled low. While frameSyncN stays high, SS stays high.
- R3: Once SS falls, it stays low without a break until 24·N SCLK rising edges have occurred. It rises together with the completion of the last byte.
- R4: The SPI link runs in mode 0. SCLK idles low and is high only while SS is low. MISO is sampled on SCLK rising edges, and each byte arrives most significant bit first.
- R5: Each LED bit cell lasts BIT_CYC clocks. The line is high for HI1_CYC clocks when the bit is 1 and for HI0_CYC clocks when the bit is 0, then low for the rest of the cell. Bits are sent most significant bit first, and bytes are sent in the order they arrived over SPI.
- R6: Within a frame the cells follow one another with no gap. Consecutive rising edges on ledOut are exactly BIT_CYC clocks apart.
- R7: While rstN is low, ssN is high, sclk is low and ledOut is low. A frame that was cut off is abandoned. The next frame restarts from its first byte.
- R8: After the last cell of a frame, ledOut stays low for at least LATCH_CYC clocks before the next frame's first cell.
- R9: With frameSyncN held low, SS falls once every 24·N·BIT_CYC + LATCH_CYC clocks, plus a fixed overhead of no more than 16·SCK_HALF + 8 clocks.
- R10: When the block is idle and frameSyncN goes low, SS is low when it is sampled one clock later.
- R11: A pixel count of zero never starts a frame.
- R12: MOSI is held low at all times, including during every fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset; returns the block to idle |
| frameSyncN | input | 1 | Active-low level that permits the start of a frame fetch |
| pixCount | input | PIX_W | Number of pixels in the strand; held stable during a frame |
| miso | input | 1 | SPI data from the host |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data to the host, held low |
| ssN | output | 1 | Active-low SPI slave select, low for a whole frame |
| ledOut | output | 1 | Encoded single-wire LED bitstream |

## Verification
The bench builds the block with PIX_W=4, BIT_CYC=20, HI1_CYC=13, HI0_CYC=6, SCK_HALF=1 and LATCH_CYC=60. With these values a full frame at the largest pixel count, fifteen pixels or 45 bytes, takes only a few thousand clocks. That lets the bench reach the maximum count, a single-pixel frame, back-to-back frames and a reset in the middle of a frame within a short run. The short latch interval and the fast SCLK keep the exact period bound of R9 and the rise-to-rise spacing of R6 easy to measure cycle by cycle.

// File: rtl/led_stream_pkg.sv
package led_stream_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic fetchGo;   // begin one SPI byte transfer
    logic loadByte;  // move the prefetched byte into the LED shifter
  } ctlStrobe_t;

  // conditions from the datapath back to the sequencer
  typedef struct packed {
    logic rxDone;    // an SPI byte has just completed
    logic bufValid;  // the prefetch register holds an unsent byte
    logic byteEnd;   // the last cell of the current byte ends this cycle
  } dpStatus_t;

endpackage

// File: rtl/led_stream_dp.sv
module led_stream_dp
  import led_stream_pkg::*;
#(
  parameter int BIT_CYC  = 154,
  parameter int HI1_CYC  = 100,
  parameter int HI0_CYC  = 46,
  parameter int SCK_HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       miso,
  input  ctlStrobe_t strb,
  output dpStatus_t  stat,
  output logic       sclk,
  output logic       ledOut
);

  localparam int CELL_W = $clog2(BIT_CYC);
  localparam int HALF_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(BIT_CYC - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCK_HALF - 1);

  // ---------------- SPI byte receiver (mode 0) ----------------
  logic              spiBusy;
  logic              sclkQ;
  logic [HALF_W-1:0] halfCnt;
  logic [2:0]        rxBit;
  logic [7:0]        rxShift;
  logic [7:0]        rxBuf;
  logic              bufValid;
  logic              halfEnd;
  logic              rxDone;

  assign halfEnd = spiBusy && (halfCnt == HALF_LAST);
  assign rxDone  = halfEnd && sclkQ && (rxBit == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiBusy  <= 1'b0;
      sclkQ    <= 1'b0;
      halfCnt  <= '0;
      rxBit    <= '0;
      rxShift  <= '0;
      rxBuf    <= '0;
      bufValid <= 1'b0;
    end else begin
      if (strb.fetchGo) begin
        spiBusy <= 1'b1;
        sclkQ   <= 1'b0;
        halfCnt <= '0;
        rxBit   <= '0;
      end else if (spiBusy) begin
        if (halfEnd) begin
          halfCnt <= '0;
          sclkQ   <= ~sclkQ;
          if (!sclkQ)              rxShift <= {rxShift[6:0], miso};
          else if (rxBit == 3'd7)  spiBusy <= 1'b0;
          else                     rxBit   <= rxBit + 3'd1;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
      if (rxDone) begin
        rxBuf    <= rxShift;
        bufValid <= 1'b1;
      end else if (strb.loadByte) begin
        bufValid <= 1'b0;
      end
    end
  end

  // ---------------- LED cell encoder ----------------
  logic              ledActive;
  logic [7:0]        ledShift;
  logic [2:0]        ledBit;
  logic [CELL_W-1:0] cellCnt;
  logic [CELL_W-1:0] hiLen;
  logic              cellEnd;

  assign cellEnd = ledActive && (cellCnt == CELL_LAST);
  assign hiLen   = ledShift[7] ? CELL_W'(HI1_CYC) : CELL_W'(HI0_CYC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledActive <= 1'b0;
      ledShift  <= '0;
      ledBit    <= '0;
      cellCnt   <= '0;
    end else if (strb.loadByte) begin
      ledActive <= 1'b1;
      ledShift  <= rxBuf;
      ledBit    <= '0;
      cellCnt   <= '0;
    end else if (ledActive) begin
      if (cellEnd) begin
        cellCnt <= '0;
        if (ledBit == 3'd7) begin
          ledActive <= 1'b0;
        end else begin
          ledBit   <= ledBit + 3'd1;
          ledShift <= {ledShift[6:0], 1'b0};
        end
      end else begin
        cellCnt <= cellCnt + 1'b1;
      end
    end
  end

  assign sclk          = sclkQ;
  assign ledOut        = ledActive && (cellCnt < hiLen);
  assign stat.rxDone   = rxDone;
  assign stat.bufValid = bufValid;
  assign stat.byteEnd  = cellEnd && (ledBit == 3'd7);

endmodule

// File: rtl/led_stream_ctl.sv
module led_stream_ctl
  import led_stream_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LATCH_CYC = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSyncN,
  input  logic [PIX_W-1:0] pixCount,
  input  dpStatus_t        stat,
  output ctlStrobe_t       strb,
  output logic             ssN
);

  localparam int CNT_W = PIX_W + 2;
  localparam int LAT_W = $clog2(LATCH_CYC + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATCH_CYC - 1);

  typedef enum logic [1:0] {sIdle, sPrime, sRun, sLatch} state_t;

  state_t           state;
  logic [CNT_W-1:0] total, fetched, sent;
  logic [CNT_W-1:0] frameBytes;
  logic [LAT_W-1:0] latCnt;
  logic             startFrame;

  assign frameBytes    = CNT_W'(pixCount) * CNT_W'(3);
  assign startFrame    = (state == sIdle) && !frameSyncN && (pixCount != '0);
  assign strb.loadByte = ((state == sPrime) && stat.bufValid) ||
                         ((state == sRun) && stat.byteEnd && (sent != total));
  assign strb.fetchGo  = startFrame || (strb.loadByte && (fetched != total));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= sIdle;
      total   <= '0;
      fetched <= '0;
      sent    <= '0;
      latCnt  <= '0;
      ssN     <= 1'b1;
    end else begin
      if (startFrame) begin
        total   <= frameBytes;
        fetched <= CNT_W'(1);
        sent    <= '0;
        ssN     <= 1'b0;
      end else begin
        if (strb.fetchGo)  fetched <= fetched + 1'b1;
        if (strb.loadByte) sent    <= sent + 1'b1;
        if (stat.rxDone && (fetched == total)) ssN <= 1'b1;
      end

      unique case (state)
        sIdle:  if (startFrame) state <= sPrime;
        sPrime: if (stat.bufValid) state <= sRun;
        sRun:   if (stat.byteEnd && (sent == total)) begin
                  state  <= sLatch;
                  latCnt <= '0;
                end
        sLatch: if (latCnt == LAT_LAST) state <= sIdle;
                else latCnt <= latCnt + 1'b1;
        default: state <= sIdle;
      endcase
    end
  end

endmodule

// File: rtl/led_frame_streamer.sv
module led_frame_streamer
  import led_stream_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int BIT_CYC   = 154,
  parameter int HI1_CYC   = 100,
  parameter int HI0_CYC   = 46,
  parameter int SCK_HALF  = 4,
  parameter int LATCH_CYC = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSyncN,
  input  logic [PIX_W-1:0] pixCount,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             ssN,
  output logic             ledOut
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  led_stream_ctl #(.PIX_W(PIX_W), .LATCH_CYC(LATCH_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .pixCount(pixCount),
    .stat(stat), .strb(strb), .ssN(ssN)
  );

  led_stream_dp #(.BIT_CYC(BIT_CYC), .HI1_CYC(HI1_CYC), .HI0_CYC(HI0_CYC),
                  .SCK_HALF(SCK_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .miso(miso), .strb(strb), .stat(stat),
    .sclk(sclk), .ledOut(ledOut)
  );

  assign mosi = 1'b0;  // R12: nothing is ever sent to the host

endmodule

// File: rtl/led_frame_streamer_chk.sv
module led_frame_streamer_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameSyncN,
  input logic [PIX_W-1:0] pixCount,
  input logic             sclk,
  input logic             ssN,
  input logic             ledOut
);

  localparam int RC_W = PIX_W + 5;

  logic [RC_W-1:0] riseCnt, expRise;
  logic            sclkD, ssD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
      expRise <= '0;
      sclkD   <= 1'b0;
      ssD     <= 1'b1;
    end else begin
      sclkD <= sclk;
      ssD   <= ssN;
      if (ssD && !ssN) begin
        riseCnt <= '0;
        expRise <= RC_W'(pixCount) * RC_W'(24);
      end else if (sclk && !sclkD) begin
        riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  // R2: a frame opens only on an edge where frame-sync was low
  a_r2_sync_gate: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> !$past(frameSyncN));

  // R3: SS is released only after the whole frame has been clocked in
  a_r3_whole_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> (riseCnt == expRise));

  // R4: SCLK is high only inside a selected transfer
  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !ssN);

  // R7: reset forces the outputs quiet
  a_r7_reset_idle: assert property (@(posedge clk)
    !rstN |=> (ssN && !sclk && !ledOut));

  // R11: with no pixels configured, an idle block stays idle
  a_r11_zero_pixels: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && !ledOut && pixCount == '0) |=> ssN);

endmodule

bind led_frame_streamer led_frame_streamer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .pixCount(pixCount),
  .sclk(sclk), .ssN(ssN), .ledOut(ledOut)
);

// File: tb/sim_led_frame_streamer.sv
`timescale 1ns/1ps
module sim_led_frame_streamer;

  localparam int PIX_W = 4;
  localparam int BIT   = 20;
  localparam int HI1   = 13;
  localparam int HI0   = 6;
  localparam int SCKH  = 1;
  localparam int LATCH = 60;
  localparam int WD    = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic frameSyncN = 1'b1;
  logic [PIX_W-1:0] pixCount = '0;
  logic miso = 1'b0;
  logic sclk, mosi, ssN, ledOut;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  int sIdx = 0;
  logic [7:0] txData [0:47];

  always #2.5 clk = ~clk;

  led_frame_streamer #(.PIX_W(PIX_W), .BIT_CYC(BIT), .HI1_CYC(HI1), .HI0_CYC(HI0),
                       .SCK_HALF(SCKH), .LATCH_CYC(LATCH)) u0 (
    .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .pixCount(pixCount),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ssN(ssN), .ledOut(ledOut)
  );

  // host model: SPI mode 0 slave, data changes on SCLK falling edges
  always @(negedge ssN) begin
    sIdx = 0;
    miso = txData[0][7];
  end
  always @(negedge sclk) begin
    if (!ssN) begin
      sIdx++;
      if (sIdx < 384) miso = txData[sIdx / 8][7 - (sIdx % 8)];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int frameCycles(input int pix);
    return 24 * pix * BIT + LATCH;
  endfunction

  task automatic fillRandom(input int nBytes);
    for (int i = 0; i < 48; i++) txData[i] = (i < nBytes) ? 8'($urandom) : 8'h00;
  endtask

  task automatic waitSsFall(output int lat, output int tFall);
    lat = 0;
    while (ssN && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    tFall = cyc;
  endtask

  // decode one frame from the ports; call right after SS is seen low
  task automatic streamCheck(input int pix, input string tag,
                             output int tFirstRise, output int tLastFall);
    int cells = 0, rises = 0, mosiBad = 0, hiBad = 0, stall = 0;
    int dataBad = 0, ssEarly = 0, hi = 0, lastRise = -1, nBit = 0, bIdx = 0, guard = 0;
    int total = 24 * pix;
    logic [7:0] cur = 8'h00;
    logic pl = 1'b0, ps = 1'b0;
    tFirstRise = -1;
    tLastFall = -1;
    while (!(cells == total && ssN) && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!ssN) begin
        if (sclk && !ps) rises++;
        if (mosi) mosiBad++;
      end else if (rises < total) begin
        ssEarly++;
      end
      if (ledOut) begin
        if (!pl) begin
          if (lastRise >= 0 && cyc - lastRise != BIT) stall++;
          if (tFirstRise < 0) tFirstRise = cyc;
          lastRise = cyc;
        end
        hi++;
      end else if (pl) begin
        bit b;
        b = (hi >= (HI0 + HI1 + 1) / 2);
        if (hi != (b ? HI1 : HI0)) hiBad++;
        cur = {cur[6:0], b};
        nBit++; cells++; hi = 0;
        tLastFall = cyc;
        if (nBit == 8) begin
          if (cur != txData[bIdx]) dataBad++;
          bIdx++; nBit = 0;
        end
      end
      pl = ledOut;
      ps = sclk;
    end
    check(cells == total, "R1", {tag, " cell count"}, cells, total);
    check(bIdx == 3 * pix, "R1", {tag, " byte count"}, bIdx, 3 * pix);
    check(rises == total && ssEarly == 0, "R3", {tag, " SCLK rises under one SS"}, rises, total);
    check(dataBad == 0, "R4", {tag, " bytes decoded in arrival order"}, dataBad, 0);
    check(hiBad == 0, "R5", {tag, " high phase widths"}, hiBad, 0);
    check(stall == 0, "R6", {tag, " cell spacing"}, stall, 0);
    check(mosiBad == 0, "R12", {tag, " MOSI low"}, mosiBad, 0);
  endtask

  initial begin
    int lat, tA, tB, fr1, lf1, fr2, lf2, cnt;
    void'($urandom(32'h00C0FFEE));
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(ssN && !sclk && !ledOut, "R7", "outputs under reset", {ssN, sclk, ledOut}, 3'b100);
    check(mosi == 1'b0, "R12", "MOSI under reset", mosi, 0);
    rstN = 1'b1;

    // R2: frame-sync high blocks any frame
    pixCount = 4'd3;
    cnt = 0;
    repeat (200) begin @(negedge clk); if (!ssN || sclk) cnt++; end
    check(cnt == 0, "R2", "SS or SCLK active while sync high", cnt, 0);

    // R11: zero pixels never starts
    pixCount = 4'd0;
    frameSyncN = 1'b0;
    cnt = 0;
    repeat (200) begin @(negedge clk); if (!ssN || ledOut) cnt++; end
    check(cnt == 0, "R11", "activity with zero pixels", cnt, 0);
    frameSyncN = 1'b1;

    // directed corner frames then random frames, each started from idle
    for (int f = 0; f < 8; f++) begin
      int pix;
      pix = (f == 0) ? 1 : (f == 1) ? 15 : 1 + int'($urandom % 5);
      fillRandom(3 * pix);
      if (f == 0) begin txData[0] = 8'hFF; txData[1] = 8'h00; txData[2] = 8'hA5; end
      pixCount = PIX_W'(pix);
      repeat (LATCH + BIT + 5) @(negedge clk);
      frameSyncN = 1'b0;
      waitSsFall(lat, tA);
      check(lat == 1, "R10", $sformatf("frame %0d SS latency", f), lat, 1);
      frameSyncN = 1'b1;
      streamCheck(pix, $sformatf("frame %0d", f), fr1, lf1);
    end

    // free-running frames: R8 latch gap and R9 period
    repeat (LATCH + BIT + 5) @(negedge clk);
    pixCount = 4'd2;
    fillRandom(6);
    frameSyncN = 1'b0;
    waitSsFall(lat, tA);
    streamCheck(2, "free 1", fr1, lf1);
    waitSsFall(lat, tB);
    streamCheck(2, "free 2", fr2, lf2);
    check(fr2 - lf1 >= LATCH, "R8", "low gap between frames", fr2 - lf1, LATCH);
    check((tB - tA >= frameCycles(2)) && (tB - tA <= frameCycles(2) + 16 * SCKH + 8),
          "R9", "free-run SS period", tB - tA, frameCycles(2));
    frameSyncN = 1'b1;

    // R7: reset in the middle of a frame, then a clean restart
    repeat (LATCH + BIT + 5) @(negedge clk);
    pixCount = 4'd4;
    fillRandom(12);
    frameSyncN = 1'b0;
    waitSsFall(lat, tA);
    frameSyncN = 1'b1;
    repeat (300) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(ssN && !sclk && !ledOut, "R7", "outputs after mid-frame reset",
          {ssN, sclk, ledOut}, 3'b100);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    frameSyncN = 1'b0;
    waitSsFall(lat, tA);
    frameSyncN = 1'b1;
    streamCheck(4, "after reset R7", fr1, lf1);

    repeat (LATCH + 10) @(negedge clk);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule